// File: doc/BRIEF.md
# CAN Fault Confinement State Tracker

This block follows the fault confinement state of one CAN node. It holds the transmit and receive error counters and moves them on single-cycle pulses from the protocol logic, which detects the errors itself. From the counters it works out which state the node is in. The four states are error-active, error-warning, error-passive and bus-off. It packs the counters and a one-hot state flag group into a status word. It raises a one-cycle event on every change of state.

When the transmit counter is driven past its maximum, the node goes bus-off. The block then drops the controller-enable output and flags every transmit slot for abort. Recovery starts only on a start request. After the request, the block watches the sampled bit stream and counts runs of 11 consecutive recessive bits. After 128 such runs it clears both counters and returns the node to error-active.

Every input is a plain strobe or level sampled on the clock. No input or output carries a data stream, so the block has no valid/ready handshake and never applies back-pressure. A pulse is acted on in the cycle it is present and is never held over.

Top module: `can_fault_state`

## Requirements
- R1: `status_o` holds the receive counter in bits 7:0 and the transmit counter in bits 15:8. Bit 16 reads 0. After reset, `status_o` is 0, `ctrl_en_o` is 1, `state_evt_o` is 0 and `tx_abort_o` is 0.
- R2: A `tec_inc` pulse adds 8 to the transmit counter and a `rec_inc` pulse adds 1 to the receive counter. A `tec_dec` or `rec_dec` pulse subtracts 1, but never below 0. Increment and decrement of the same counter in one cycle give the net sum. The receive counter saturates at 255.
- R3: Bit 17 (warning) is set when either counter is 96 or more and neither higher state applies.
- R4: Bit 18 (passive) is set when either counter is 128 or more and the node is not bus-off. At most one of bits 19:17 is set at any time, with bus-off taking priority over passive and passive over warning.
- R5: An increment that would take the transmit counter above 255 puts the node in bus-off. Bit 19 is then set, the transmit counter reads 255 and `ctrl_en_o` is 0.
- R6: While the node is bus-off, the counter pulses have no effect on bits 15:0.
- R7: In bus-off, bits on the bus are ignored until `start_req` has been seen.
- R8: After `start_req`, the node leaves bus-off on the bit that completes the 128th run of 11 consecutive recessive bits (`rx_bit`=1 with `bit_valid`). A dominant bit resets the run in progress.
- R9: A new `start_req` while bus-off restarts the idle count from zero. This includes a request in the same cycle as the bit that would have completed recovery; in that case the request wins.
- R10: Leaving bus-off clears both counters to 0 and sets `ctrl_en_o` back to 1.
- R11: `state_evt_o` is high for exactly the one cycle that follows each state change, including the return to error-active.
- R12: `tx_abort_o` is all ones in the event cycle of a bus-off entry and all zeros in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe: `rx_bit` holds a sampled bus bit |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive |
| tec_inc | input | 1 | Transmit error pulse (+8) |
| tec_dec | input | 1 | Transmit success pulse (-1) |
| rec_inc | input | 1 | Receive error pulse (+1) |
| rec_dec | input | 1 | Receive success pulse (-1) |
| start_req | input | 1 | Request to begin bus-off recovery |
| status_o | output | 20 | Counters and state flags |
| state_evt_o | output | 1 | One-cycle state-change event |
| ctrl_en_o | output | 1 | Controller may take part in bus traffic |
| tx_abort_o | output | 16 | Per-slot abort flags on bus-off entry |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is an increment and a decrement of the transmit counter. The bench drives both pulses together from a count of 95 and expects exactly 102, which also crosses the warning threshold.

The second pair is a start request and the recessive bit that would complete the 128th idle run. The bench lines these up on the exact cycle. It expects the node to stay bus-off, and then to need a full 1408 further recessive bits before it returns to error-active.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_WARN    = 2'd1,
    FC_PASSIVE = 2'd2,
    FC_BUSOFF  = 2'd3
  } fc_state_e;
endpackage

// File: rtl/cfs_err_counters.sv
module cfs_err_counters #(
  parameter int CNT_W    = 8,
  parameter int TEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tec_inc,
  input  logic             tec_dec,
  input  logic             rec_inc,
  input  logic             rec_dec,
  input  logic             freeze,
  input  logic             clear,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic             tec_ovf
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << CNT_W) - 1);

  logic [SUM_W-1:0] tec_sum, rec_sum;
  logic [CNT_W-1:0] tec_nx, rec_nx;

  always_comb begin
    tec_sum = {2'b00, tec} + (tec_inc ? SUM_W'(TEC_STEP) : '0);
    if (tec_dec && tec_sum != '0) tec_sum = tec_sum - 1'b1;
    rec_sum = {2'b00, rec} + (rec_inc ? SUM_W'(1) : '0);
    if (rec_dec && rec_sum != '0) rec_sum = rec_sum - 1'b1;
    tec_ovf = !freeze && (tec_sum > MAXV);
    tec_nx  = (tec_sum > MAXV) ? MAXV[CNT_W-1:0] : tec_sum[CNT_W-1:0];
    rec_nx  = (rec_sum > MAXV) ? MAXV[CNT_W-1:0] : rec_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tec <= '0;
      rec <= '0;
    end else if (!freeze) begin
      tec <= tec_nx;
      rec <= rec_nx;
    end
  end
endmodule

// File: rtl/cfs_idle_recovery.sv
module cfs_idle_recovery #(
  parameter int RUN_LEN   = 11,
  parameter int IDLE_NEED = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_busoff,
  input  logic start_req,
  input  logic bit_valid,
  input  logic rx_bit,
  output logic done
);
  localparam int RUN_W  = $clog2(RUN_LEN + 1);
  localparam int IDLE_W = $clog2(IDLE_NEED + 1);

  logic              armed_q;
  logic [RUN_W-1:0]  run_q;
  logic [IDLE_W-1:0] idle_q;
  logic              run_end;

  always_comb begin
    run_end = bit_valid && rx_bit && (run_q == RUN_W'(RUN_LEN - 1));
    done    = armed_q && !start_req && run_end &&
              (idle_q == IDLE_W'(IDLE_NEED - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !in_busoff) begin
      armed_q <= 1'b0;
      run_q   <= '0;
      idle_q  <= '0;
    end else if (start_req) begin
      armed_q <= 1'b1;
      run_q   <= '0;
      idle_q  <= '0;
    end else if (armed_q && bit_valid) begin
      if (!rx_bit) begin
        run_q <= '0;
      end else if (run_end) begin
        run_q  <= '0;
        idle_q <= idle_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfs_classify.sv
module cfs_classify
  import cfs_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  input  logic             busoff,
  output fc_state_e        state
);
  always_comb begin
    if (busoff)
      state = FC_BUSOFF;
    else if (int'(tec) >= PASS_LIM || int'(rec) >= PASS_LIM)
      state = FC_PASSIVE;
    else if (int'(tec) >= WARN_LIM || int'(rec) >= WARN_LIM)
      state = FC_WARN;
    else
      state = FC_ACTIVE;
  end
endmodule

// File: rtl/can_fault_state.sv
module can_fault_state
  import cfs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TEC_STEP  = 8,
  parameter int WARN_LIM  = 96,
  parameter int PASS_LIM  = 128,
  parameter int RUN_LEN   = 11,
  parameter int IDLE_NEED = 128,
  parameter int TX_SLOTS  = 16,
  localparam int STAT_W   = 2 * CNT_W + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_valid,
  input  logic                rx_bit,
  input  logic                tec_inc,
  input  logic                tec_dec,
  input  logic                rec_inc,
  input  logic                rec_dec,
  input  logic                start_req,
  output logic [STAT_W-1:0]   status_o,
  output logic                state_evt_o,
  output logic                ctrl_en_o,
  output logic [TX_SLOTS-1:0] tx_abort_o
);
  logic [CNT_W-1:0] tec, rec;
  logic             tec_ovf, rec_done, bo_q;
  fc_state_e        cur_st, prev_q;

  cfs_err_counters #(.CNT_W(CNT_W), .TEC_STEP(TEC_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tec_inc(tec_inc), .tec_dec(tec_dec),
    .rec_inc(rec_inc), .rec_dec(rec_dec),
    .freeze(bo_q), .clear(rec_done),
    .tec(tec), .rec(rec), .tec_ovf(tec_ovf)
  );

  cfs_idle_recovery #(.RUN_LEN(RUN_LEN), .IDLE_NEED(IDLE_NEED)) u_rcv (
    .clk(clk), .rst_n(rst_n), .in_busoff(bo_q), .start_req(start_req),
    .bit_valid(bit_valid), .rx_bit(rx_bit), .done(rec_done)
  );

  cfs_classify #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_cls (
    .tec(tec), .rec(rec), .busoff(bo_q), .state(cur_st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bo_q   <= 1'b0;
      prev_q <= FC_ACTIVE;
    end else begin
      prev_q <= cur_st;
      if (rec_done)     bo_q <= 1'b0;
      else if (tec_ovf) bo_q <= 1'b1;
    end
  end

  always_comb begin
    status_o    = {cur_st == FC_BUSOFF, cur_st == FC_PASSIVE,
                   cur_st == FC_WARN, 1'b0, tec, rec};
    state_evt_o = (cur_st != prev_q);
    ctrl_en_o   = !bo_q;
    tx_abort_o  = (state_evt_o && cur_st == FC_BUSOFF) ? '1 : '0;
  end
endmodule

// File: rtl/can_fault_state_chk.sv
module can_fault_state_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [19:0] status_o,
  input logic        state_evt_o,
  input logic        ctrl_en_o,
  input logic [15:0] tx_abort_o
);
  a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_o[19:17]));
  a_r5_tec_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[19]) |-> (status_o[15:8] == 8'hFF && !ctrl_en_o));
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[19] |=> ($stable(status_o[15:0]) || status_o[15:0] == 16'h0));
  a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[19]) |-> (status_o[15:0] == 16'h0 && ctrl_en_o));
  a_r11_event: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[19:17] != $past(status_o[19:17])) |-> state_evt_o);
  a_r12_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort_o != 16'h0) |-> (state_evt_o && status_o[19]));
endmodule

bind can_fault_state can_fault_state_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status_o(status_o),
  .state_evt_o(state_evt_o), .ctrl_en_o(ctrl_en_o), .tx_abort_o(tx_abort_o)
);

// File: tb/can_fault_state_bench.sv
`timescale 1ns/1ps
module can_fault_state_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 0, rx_bit = 0, tec_inc = 0, tec_dec = 0;
  logic rec_inc = 0, rec_dec = 0, start_req = 0;
  logic [19:0] status_o;
  logic        state_evt_o, ctrl_en_o;
  logic [15:0] tx_abort_o;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  can_fault_state u_can_fault_state (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .tec_inc(tec_inc), .tec_dec(tec_dec), .rec_inc(rec_inc), .rec_dec(rec_dec),
    .start_req(start_req), .status_o(status_o), .state_evt_o(state_evt_o),
    .ctrl_en_o(ctrl_en_o), .tx_abort_o(tx_abort_o)
  );

  // {tec_inc, tec_dec, rec_inc, rec_dec} , repeat count , expected status
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {4'b0010, 8'd95,  20'h0005F},   // R2 R1
    {4'b0010, 8'd1,   20'h20060},   // R3 warning at 96
    {4'b0001, 8'd1,   20'h0005F},   // R3 back below
    {4'b1000, 8'd16,  20'h4805F},   // R4 tec 128
    {4'b0100, 8'd33,  20'h05F5F},   // R2 tec down
    {4'b0010, 8'd33,  20'h45F80},   // R4 rec 128
    {4'b0001, 8'd200, 20'h05F00},   // R2 floor at 0
    {4'b1100, 8'd1,   20'h26600},   // R2 inc+dec net +7
    {4'b0010, 8'd255, 20'h466FF},   // R4 rec 255
    {4'b0010, 8'd5,   20'h466FF},   // R2 rec saturates
    {4'b0001, 8'd255, 20'h26600}    // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulses(input logic [3:0] ops, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {tec_inc, tec_dec, rec_inc, rec_dec} = ops;
    end
    @(negedge clk);
    {tec_inc, tec_dec, rec_inc, rec_dec} = 4'b0;
    #0.5;
  endtask

  task automatic bits(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      rx_bit = v;
    end
    @(negedge clk);
    bit_valid = 1'b0;
    rx_bit = 1'b0;
    #0.5;
  endtask

  task automatic start;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1 reset status", 32'(status_o), 32'h0);
    check("R1 reset ctrl_en", 32'(ctrl_en_o), 32'h1);
    check("R1 reset event", 32'(state_evt_o), 32'h0);
    check("R1 reset abort", 32'(tx_abort_o), 32'h0);

    for (int v = 0; v < NV; v++) begin
      pulses(VEC[v][31:28], int'(VEC[v][27:20]));
      check("R1-vector table", 32'(status_o), 32'(VEC[v][19:0]));
    end

    // R5: bus-off entry from tec 102
    pulses(4'b1000, 19);
    check("R4 tec 254 passive", 32'(status_o), 32'h4FE00);
    pulses(4'b1000, 1);
    check("R5 bus-off status", 32'(status_o), 32'h8FF00);
    check("R5 ctrl_en low", 32'(ctrl_en_o), 32'h0);
    check("R11 event on bus-off", 32'(state_evt_o), 32'h1);
    check("R12 abort all", 32'(tx_abort_o), 32'hFFFF);
    @(negedge clk); #0.5;
    check("R11 event one cycle", 32'(state_evt_o), 32'h0);
    check("R12 abort cleared", 32'(tx_abort_o), 32'h0);

    // R6: counters frozen
    pulses(4'b0110, 3);
    check("R6 pulses ignored", 32'(status_o), 32'h8FF00);
    // R7: no start, idle bits ignored
    bits(1'b1, 1500);
    check("R7 no recovery without start", 32'(status_o), 32'h8FF00);

    // R8: recovery, dominant resets run
    start();
    bits(1'b1, 127 * 11 + 10);
    bits(1'b0, 1);
    check("R8 still bus-off after dominant", 32'(status_o), 32'h8FF00);
    bits(1'b1, 10);
    check("R8 run restarted", 32'(status_o), 32'h8FF00);
    bits(1'b1, 1);
    check("R10 counters cleared", 32'(status_o), 32'h0);
    check("R10 ctrl_en high", 32'(ctrl_en_o), 32'h1);
    check("R11 event on recovery", 32'(state_evt_o), 32'h1);
    check("R12 no abort on recovery", 32'(tx_abort_o), 32'h0);

    // R9: restart of idle count
    pulses(4'b1000, 31);
    check("R4 tec 248", 32'(status_o), 32'h4F800);
    pulses(4'b1000, 1);
    check("R5 second bus-off", 32'(status_o), 32'h8FF00);
    start();
    bits(1'b1, 1100);
    start();
    bits(1'b1, 127 * 11 + 10);
    @(negedge clk);
    bit_valid = 1'b1; rx_bit = 1'b1; start_req = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0; rx_bit = 1'b0; start_req = 1'b0;
    #0.5;
    check("R9 start wins over final bit", 32'(status_o), 32'h8FF00);
    bits(1'b1, 127 * 11 + 10);
    check("R9 count restarted", 32'(status_o), 32'h8FF00);
    bits(1'b1, 1);
    check("R9 recovered after full count", 32'(status_o), 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule